// File: doc/BRIEF.md
# ECC Event Logging Register File

This block sits beside a memory controller's ECC decoder and keeps software's view of memory errors. The decoder sends it a one-cycle pulse for each correctable error and each uncorrectable error, each with the failing address. The block counts the two classes separately. It keeps the address of the first uncorrectable error since the last clear and the address of the most recent correctable error. It raises a level-high interrupt while an enabled class has a pending event.

Software reaches the block through a simple 32-bit register bus with byte offsets and a 4-byte stride. Reads return one cycle after the request. Writes to every register except the key register are ignored until software has unlocked the block with a fixed key value. The usual service routine reads the counts and both addresses, then writes the clear bit to 1 and back to 0.

Top module: `ecc_event_regs`

## Requirements
- R1: After reset the block is locked, every register reads 0 and `irq` is 0.
- R2: A write of 0xFC600309 to offset 0x00 unlocks the block, and a write of any other value to offset 0x00 locks it. Offset 0x00 reads 1 in bit 0 when unlocked and 0 when locked, and its other bits read 0.
- R3: While locked, writes to offsets 0x04 and 0x50 leave those registers unchanged. Reads of every offset work whether the block is locked or unlocked.
- R4: At offset 0x04, bit 7 (ECC enabled) and bit 4 (DRAM type, 1 = DDR4, 0 = DDR3) are writable while unlocked, and every other bit reads 0.
- R5: At offset 0x50, bits 23:16 count correctable error pulses. The count stops at 255 instead of wrapping.
- R6: At offset 0x50, bits 15:12 count uncorrectable error pulses. The count stops at 15 instead of wrapping.
- R7: Offset 0x58 holds the address of the first uncorrectable error after a clear or after reset. Later uncorrectable errors do not change it.
- R8: Offset 0x5C holds the address of the most recent correctable error.
- R9: Bit 31 of offset 0x50 reads back as written. While it is 1, both counts and both pending flags are held at 0, and error pulses that arrive are dropped, including their addresses.
- R10: Bit 0 of offset 0x50 enables the correctable interrupt and bit 1 enables the uncorrectable one. `irq` is registered, and it equals the OR over both classes of enable AND pending. It follows a pulse or an enable change one cycle after the register updates.
- R11: Error pulses are logged while the block is locked.
- R12: Writes to offsets 0x58 and 0x5C, and to unmapped offsets, have no effect. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | REG_AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request, held otherwise |
| ce_pulse | input | 1 | One-cycle correctable error event |
| ce_addr | input | ERR_AW | Address of the correctable error |
| ue_pulse | input | 1 | One-cycle uncorrectable error event |
| ue_addr | input | ERR_AW | Address of the uncorrectable error |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit error addresses, an 8-bit correctable count and a 4-bit uncorrectable count. With these sizes both counts reach their ceilings within a few hundred pulses. A directed burst therefore drives each count into saturation, and a random sequence then mixes error pulses, key writes, enable and clear writes, and reads against a bench model. The model covers first-address and last-address capture, the locking rules and the interrupt level.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'hFC60_0309;

  localparam int OFF_KEY    = 'h00;
  localparam int OFF_CFG    = 'h04;
  localparam int OFF_CTRL   = 'h50;
  localparam int OFF_UEADDR = 'h58;
  localparam int OFF_CEADDR = 'h5C;

  localparam int CFG_ECC_BIT  = 7;
  localparam int CFG_DDR4_BIT = 4;
  localparam int CTRL_CLR_BIT = 31;
  localparam int CTRL_CE_LSB  = 16;
  localparam int CTRL_UE_LSB  = 12;

  typedef struct packed {
    logic ecc_on;
    logic ddr4;
  } cfg_t;
endpackage

// File: rtl/ecc_key_lock.sv
module ecc_key_lock
  import ecc_log_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        key_wr,
  input  logic [31:0] key_val,
  output logic        unlocked
);
  always_ff @(posedge clk) begin
    if (rst)         unlocked <= 1'b0;
    else if (key_wr) unlocked <= (key_val == UNLOCK_KEY);
  end
endmodule

// File: rtl/ecc_event_tracker.sv
module ecc_event_tracker #(
  parameter int CNT_W      = 8,
  parameter int ADDR_W     = 32,
  parameter bit KEEP_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              evt,
  input  logic [ADDR_W-1:0] evt_addr,
  output logic [CNT_W-1:0]  count,
  output logic              pending,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic take;
  assign take = evt && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count   <= '0;
      pending <= 1'b0;
    end else if (evt) begin
      if (count != CNT_MAX) count <= count + 1'b1;
      pending <= 1'b1;
    end
  end

  generate
    if (KEEP_FIRST) begin : g_first
      always_ff @(posedge clk) begin
        if (rst)                      addr <= '0;
        else if (take && count == '0) addr <= evt_addr;
      end
    end else begin : g_last
      always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (take) addr <= evt_addr;
      end
    end
  endgenerate
endmodule

// File: rtl/ecc_event_regs.sv
module ecc_event_regs
  import ecc_log_pkg::*;
#(
  parameter int REG_AW   = 8,
  parameter int ERR_AW   = 32,
  parameter int CE_CNT_W = 8,
  parameter int UE_CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ce_pulse,
  input  logic [ERR_AW-1:0] ce_addr,
  input  logic              ue_pulse,
  input  logic [ERR_AW-1:0] ue_addr,
  output logic              irq
);
  localparam int NCLASS = 2;

  logic wr, rd, unlocked;
  logic sel_key, sel_cfg, sel_ctrl, sel_ueaddr, sel_ceaddr;
  cfg_t cfg_q;
  logic clr_q;
  logic [NCLASS-1:0] en_q, pend;
  logic [CE_CNT_W-1:0] ce_cnt;
  logic [UE_CNT_W-1:0] ue_cnt;
  logic [ERR_AW-1:0] ue_addr_q, ce_addr_q;
  logic [31:0] rdata_n;

  assign wr = bus_valid && bus_write;
  assign rd = bus_valid && !bus_write;
  assign sel_key    = bus_addr == REG_AW'(OFF_KEY);
  assign sel_cfg    = bus_addr == REG_AW'(OFF_CFG);
  assign sel_ctrl   = bus_addr == REG_AW'(OFF_CTRL);
  assign sel_ueaddr = bus_addr == REG_AW'(OFF_UEADDR);
  assign sel_ceaddr = bus_addr == REG_AW'(OFF_CEADDR);

  ecc_key_lock u_lock (
    .clk(clk), .rst(rst), .key_wr(wr && sel_key),
    .key_val(bus_wdata), .unlocked(unlocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      clr_q <= 1'b0;
      en_q  <= '0;
    end else if (wr && unlocked) begin
      if (sel_cfg) begin
        cfg_q.ecc_on <= bus_wdata[CFG_ECC_BIT];
        cfg_q.ddr4   <= bus_wdata[CFG_DDR4_BIT];
      end
      if (sel_ctrl) begin
        clr_q <= bus_wdata[CTRL_CLR_BIT];
        en_q  <= bus_wdata[NCLASS-1:0];
      end
    end
  end

  ecc_event_tracker #(.CNT_W(CE_CNT_W), .ADDR_W(ERR_AW), .KEEP_FIRST(1'b0)) u_ce (
    .clk(clk), .rst(rst), .clear(clr_q), .evt(ce_pulse), .evt_addr(ce_addr),
    .count(ce_cnt), .pending(pend[0]), .addr(ce_addr_q)
  );

  ecc_event_tracker #(.CNT_W(UE_CNT_W), .ADDR_W(ERR_AW), .KEEP_FIRST(1'b1)) u_ue (
    .clk(clk), .rst(rst), .clear(clr_q), .evt(ue_pulse), .evt_addr(ue_addr),
    .count(ue_cnt), .pending(pend[1]), .addr(ue_addr_q)
  );

  always_comb begin
    rdata_n = '0;
    if (sel_key) rdata_n[0] = unlocked;
    if (sel_cfg) begin
      rdata_n[CFG_ECC_BIT]  = cfg_q.ecc_on;
      rdata_n[CFG_DDR4_BIT] = cfg_q.ddr4;
    end
    if (sel_ctrl) begin
      rdata_n[CTRL_CLR_BIT] = clr_q;
      rdata_n[CTRL_CE_LSB +: CE_CNT_W] = ce_cnt;
      rdata_n[CTRL_UE_LSB +: UE_CNT_W] = ue_cnt;
      rdata_n[NCLASS-1:0] = en_q;
    end
    if (sel_ueaddr) rdata_n[ERR_AW-1:0] = ue_addr_q;
    if (sel_ceaddr) rdata_n[ERR_AW-1:0] = ce_addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (rd) bus_rdata <= rdata_n;
      irq <= |(en_q & pend);
    end
  end
endmodule

// File: rtl/ecc_event_regs_chk.sv
module ecc_event_regs_chk #(
  parameter int REG_AW   = 8,
  parameter int ERR_AW   = 32,
  parameter int CE_CNT_W = 8,
  parameter int UE_CNT_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                unlocked,
  input logic                bus_valid,
  input logic                bus_write,
  input logic [REG_AW-1:0]   bus_addr,
  input logic [1:0]          cfg_bits,
  input logic                clr_q,
  input logic [1:0]          en_q,
  input logic                ce_pulse,
  input logic [CE_CNT_W-1:0] ce_cnt,
  input logic [UE_CNT_W-1:0] ue_cnt,
  input logic [ERR_AW-1:0]   ue_addr_q,
  input logic                irq
);
  localparam logic [CE_CNT_W-1:0] CE_MAX = '1;

  assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && !unlocked && bus_addr == REG_AW'('h04)) |=> $stable(cfg_bits));

  assert_ce_saturate_R5: assert property (@(posedge clk) disable iff (rst)
    (ce_cnt == CE_MAX && ce_pulse && !clr_q) |=> ce_cnt == CE_MAX);

  assert_ue_first_R7: assert property (@(posedge clk) disable iff (rst)
    (ue_cnt != '0 && !clr_q) |=> $stable(ue_addr_q));

  assert_clear_hold_R9: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> (ce_cnt == '0 && ue_cnt == '0));

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    (en_q == 2'b00) |=> !irq);
endmodule

bind ecc_event_regs ecc_event_regs_chk #(
  .REG_AW(REG_AW), .ERR_AW(ERR_AW), .CE_CNT_W(CE_CNT_W), .UE_CNT_W(UE_CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .unlocked(unlocked), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .cfg_bits(cfg_q),
  .clr_q(clr_q), .en_q(en_q), .ce_pulse(ce_pulse), .ce_cnt(ce_cnt),
  .ue_cnt(ue_cnt), .ue_addr_q(ue_addr_q), .irq(irq)
);

// File: tb/sim_ecc_event_regs.sv
module sim_ecc_event_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'hFC60_0309;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_valid = 0, bus_write = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic ce_pulse = 0, ue_pulse = 0;
  logic [31:0] ce_addr = 0, ue_addr = 0;
  logic irq;

  int checks = 0, errors = 0;

  logic m_unl, m_ecc, m_ddr4, m_clr, m_cep, m_uep;
  logic [1:0] m_en;
  logic [7:0] m_cec;
  logic [3:0] m_uec;
  logic [31:0] m_uea, m_cea;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_event_regs u0 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ce_pulse(ce_pulse), .ce_addr(ce_addr), .ue_pulse(ue_pulse),
    .ue_addr(ue_addr), .irq(irq)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return {31'b0, m_unl};
      8'h04: return {24'b0, m_ecc, 2'b0, m_ddr4, 4'b0};
      8'h50: return {m_clr, 7'b0, m_cec, m_uec, 10'b0, m_en};
      8'h58: return m_uea;
      8'h5C: return m_cea;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_en[0] && m_cep) || (m_en[1] && m_uep);
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_unl = 0; m_ecc = 0; m_ddr4 = 0; m_clr = 0; m_cep = 0; m_uep = 0;
    m_en = 0; m_cec = 0; m_uec = 0; m_uea = 0; m_cea = 0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (a == 8'h00) m_unl = (d == KEY);
    else if (m_unl) begin
      if (a == 8'h04) begin m_ecc = d[7]; m_ddr4 = d[4]; end
      if (a == 8'h50) begin
        m_clr = d[31]; m_en = d[1:0];
        if (m_clr) begin m_cec = 0; m_uec = 0; m_cep = 0; m_uep = 0; end
      end
    end
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    @(posedge clk); #1;
  endtask

  task automatic bus_chk(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(posedge clk); #1;
    check(bus_rdata, exp_read(a), tag);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic pulse(input logic ce, input logic [31:0] cea,
                       input logic ue, input logic [31:0] uea);
    @(negedge clk);
    ce_pulse = ce; ce_addr = cea; ue_pulse = ue; ue_addr = uea;
    @(posedge clk);
    if (!m_clr) begin
      if (ce) begin
        if (m_cec != 8'hFF) m_cec++;
        m_cea = cea; m_cep = 1;
      end
      if (ue) begin
        if (m_uec == 0) m_uea = uea;
        if (m_uec != 4'hF) m_uec++;
        m_uep = 1;
      end
    end
    @(negedge clk);
    ce_pulse = 0; ue_pulse = 0;
  endtask

  task automatic irq_chk(input string tag);
    @(posedge clk); #1;
    check({31'b0, irq}, {31'b0, exp_irq()}, tag);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    check({31'b0, irq}, 32'h0, "R1 irq after reset");
    bus_chk(8'h00, "R1 key reg reset");
    bus_chk(8'h50, "R1 ctrl reset");
    bus_chk(8'h58, "R1 ue addr reset");
    // R3 locked writes ignored, R11 logging while locked
    bus_wr(8'h04, 32'h90);
    bus_chk(8'h04, "R3 cfg locked write");
    bus_wr(8'h50, 32'h3);
    bus_chk(8'h50, "R3 ctrl locked write");
    pulse(1, 32'h1000, 1, 32'h2000);
    bus_chk(8'h50, "R11 counts while locked");
    bus_chk(8'h5C, "R11 ce addr while locked");
    // R2 unlock
    bus_wr(8'h00, KEY);
    bus_chk(8'h00, "R2 unlocked readback");
    // R4 config
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_chk(8'h04, "R4 cfg bits 7 and 4");
    bus_wr(8'h04, 32'h0000_0010);
    bus_chk(8'h04, "R4 cfg ddr4 only");
    // R7 first UE address kept
    pulse(0, 0, 1, 32'h3000);
    bus_chk(8'h58, "R7 first ue addr kept");
    // R8 last CE
    pulse(1, 32'hABCD_0004, 0, 0);
    bus_chk(8'h5C, "R8 last ce addr");
    // R10 enables
    irq_chk("R10 irq masked");
    bus_wr(8'h50, 32'h1);
    check({31'b0, irq}, 32'h1, "R10 irq ce enabled");
    bus_wr(8'h50, 32'h2);
    check({31'b0, irq}, 32'h1, "R10 irq ue enabled");
    // R12 ignored writes
    bus_wr(8'h58, 32'hDEAD_BEEF);
    bus_chk(8'h58, "R12 ue addr write ignored");
    bus_wr(8'h5C, 32'hDEAD_BEEF);
    bus_chk(8'h5C, "R12 ce addr write ignored");
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_chk(8'h20, "R12 unmapped reads zero");
    // R9 clear, dropped pulse
    bus_wr(8'h50, 32'h8000_0003);
    bus_chk(8'h50, "R9 clear held");
    pulse(1, 32'h5555_0000, 1, 32'h6666_0000);
    bus_chk(8'h50, "R9 pulse dropped count");
    bus_chk(8'h5C, "R9 pulse dropped addr");
    irq_chk("R9 irq cleared");
    bus_wr(8'h50, 32'h3);
    pulse(0, 0, 1, 32'h7777_0000);
    bus_chk(8'h58, "R7 capture after clear");
    irq_chk("R10 irq ue pending");
    // R5 R6 saturation
    for (int i = 0; i < 260; i++) pulse(1, 32'(i), (i % 2) == 0, 32'(i) + 32'h100);
    bus_chk(8'h50, "R5 R6 saturated counts");
    bus_chk(8'h5C, "R8 last ce after burst");
    // R2 relock with complement
    bus_wr(8'h00, ~KEY);
    bus_chk(8'h00, "R2 relocked");
    bus_wr(8'h50, 32'h8000_0000);
    bus_chk(8'h50, "R3 clear ignored when locked");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom % 10;
      case (op)
        0, 1, 2, 3: pulse(1'($urandom), $urandom, 1'($urandom), $urandom);
        4: bus_wr(8'h00, ($urandom % 3 == 0) ? $urandom : KEY);
        5: bus_wr(8'h50, {($urandom % 4 == 0), 29'b0, 2'($urandom)});
        6: bus_wr(8'h04, $urandom);
        7: irq_chk("R10 random irq");
        default: begin
          logic [7:0] a;
          case ($urandom % 6)
            0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h50;
            3: a = 8'h58; 4: a = 8'h5C; default: a = 8'h3C;
          endcase
          bus_chk(a, "R5 R7 R8 R9 random read");
        end
      endcase
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule